// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the memory operand address for a load/store pipeline that offers eight addressing modes. Each request carries a mode code, a base register value, an index register value, a 16-bit displacement and an operand size code. The block sign-extends the displacement and scales by the operand size. For the pre-decrement and post-increment modes it also produces a base-register writeback value with an enable.

All modes except memory-indirect produce their result one cycle after the request. In memory-indirect mode the block first reads a pointer from memory at the base register's address through a request/valid read port. The pointer that comes back becomes the operand address. While that read is outstanding the block reports busy and ignores new requests.

Top module: `eff_addr_gen`

## Requirements
- R1: With `start` high and `busy` low, every mode other than memory-indirect (code 4) raises `done` for exactly one cycle on the next clock edge, together with its address. For displacement mode (code 0) the address is `base` + sign-extended `disp`.
- R2: Register-indirect mode (code 1) yields `base` as the address. Absolute mode (code 3) yields the sign-extended `disp` alone, with bit 15 of `disp` copied into all upper bits.
- R3: Indexed mode (code 2) yields `base` + `index`.
- R4: Scaled mode (code 7) yields sign-extended `disp` + `base` + (`index` shifted left by s). The size code sets s: code 0 gives s=0 (1 byte), 1 gives s=1 (2 bytes), 2 gives s=2 (4 bytes), and the spare code 3 is treated as 4 bytes.
- R5: Post-increment mode (code 5) yields `base` as the address, with `wb_en` high and `wb_data` = `base` + 2^s.
- R6: Pre-decrement mode (code 6) yields `base` − 2^s both as the address and as `wb_data`, with `wb_en` high.
- R7: `wb_en` is high only in a `done` cycle of mode 5 or 6. All arithmetic wraps modulo 2^AW.
- R8: Memory-indirect mode (code 4) raises `mem_req` and `busy` on the next edge, with `mem_addr` = `base`. Both are held, and `mem_addr` stays stable, until `mem_rvalid`. On the edge after `mem_rvalid`, `done` rises with `addr` = `mem_rdata` and `wb_en` low.
- R9: A `start` while `busy` is high is ignored. It produces no `done` and leaves `mem_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| size_code | input | 2 | Operand size code (log2 bytes, 3 = 4 bytes) |
| base | input | AW | Base register value |
| index | input | AW | Index register value |
| disp | input | 16 | Raw displacement field |
| addr | output | AW | Effective address, valid with done |
| wb_en | output | 1 | Base writeback enable |
| wb_data | output | AW | Base writeback value |
| done | output | 1 | Result strobe |
| busy | output | 1 | Pointer read outstanding |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | AW | Pointer read address |
| mem_rvalid | input | 1 | Pointer read data valid |
| mem_rdata | input | AW | Pointer read data |

## Verification
The assertions assume that `mem_rvalid` is only pulsed while `mem_req` is high. If it arrived unasked, a returned pointer could not be told apart from noise. The bench drives `mem_rvalid` only inside a pending pointer read, after a varying number of wait cycles. It also issues a conflicting `start` during that wait, so the rule that requests are ignored while busy is exercised inside the legal input space. The sweep covers every mode and size code against base, index and displacement values that reach the sign and wrap boundaries.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [2:0] {
      AM_DISP     = 3'd0,
      AM_REGIND   = 3'd1,
      AM_INDEXED  = 3'd2,
      AM_ABS      = 3'd3,
      AM_MEMIND   = 3'd4,
      AM_POSTINC  = 3'd5,
      AM_PREDEC   = 3'd6,
      AM_SCALED   = 3'd7
   } amode_e;

   // size code to shift amount; spare code 3 treated as 4 bytes
   function automatic logic [1:0] size_shift(input logic [1:0] sc);
      return (sc == 2'd3) ? 2'd2 : sc;
   endfunction
endpackage

// File: rtl/eag_sext.sv
module eag_sext #(
   parameter int DISP_W = 16,
   parameter int AW     = 32
) (
   input  logic [DISP_W-1:0] raw,
   output logic [AW-1:0]     ext
);
   generate
      if (AW == DISP_W) begin : g_same
         assign ext = raw;
      end else begin : g_ext
         assign ext = {{(AW-DISP_W){raw[DISP_W-1]}}, raw};
      end
   endgenerate
endmodule

// File: rtl/eag_step.sv
module eag_step #(
   parameter int AW       = 32,
   parameter bit SCALE_EN = 1'b1
) (
   input  logic [1:0]    size_code,
   input  logic [AW-1:0] index,
   output logic [AW-1:0] step,
   output logic [AW-1:0] scaled_index
);
   import eag_pkg::*;
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   logic [1:0] shamt;
   assign shamt = size_shift(size_code);
   assign step  = ONE << shamt;

   generate
      if (SCALE_EN) begin : g_scale
         assign scaled_index = index << shamt;
      end else begin : g_noscale
         assign scaled_index = index;
      end
   endgenerate
endmodule

// File: rtl/eag_calc.sv
module eag_calc #(
   parameter int AW = 32
) (
   input  eag_pkg::amode_e mode,
   input  logic [AW-1:0]   base,
   input  logic [AW-1:0]   index,
   input  logic [AW-1:0]   scaled_index,
   input  logic [AW-1:0]   disp_x,
   input  logic [AW-1:0]   step,
   output logic [AW-1:0]   ea,
   output logic            wb_en,
   output logic [AW-1:0]   wb_val,
   output logic            indirect
);
   import eag_pkg::*;
   logic [AW-1:0] dec_val;
   assign dec_val = base - step;

   always_comb begin
      ea       = base;
      wb_en    = 1'b0;
      wb_val   = base;
      indirect = 1'b0;
      unique case (mode)
         AM_DISP:    ea = base + disp_x;
         AM_REGIND:  ea = base;
         AM_INDEXED: ea = base + index;
         AM_ABS:     ea = disp_x;
         AM_MEMIND:  indirect = 1'b1;
         AM_POSTINC: begin
            ea     = base;
            wb_en  = 1'b1;
            wb_val = base + step;
         end
         AM_PREDEC: begin
            ea     = dec_val;
            wb_en  = 1'b1;
            wb_val = dec_val;
         end
         AM_SCALED:  ea = disp_x + base + scaled_index;
         default:    ea = base;
      endcase
   end
endmodule

// File: rtl/eag_ptr_ctl.sv
module eag_ptr_ctl #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] ptr_in,
   input  logic          rvalid,
   output logic          busy,
   output logic [AW-1:0] ptr_addr,
   output logic          land
);
   typedef enum logic {P_IDLE, P_WAIT} pstate_e;
   pstate_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= P_IDLE;
         ptr_addr <= '0;
      end else begin
         unique case (st)
            P_IDLE: if (launch) begin
               st       <= P_WAIT;
               ptr_addr <= ptr_in;
            end
            P_WAIT: if (rvalid) st <= P_IDLE;
            default: st <= P_IDLE;
         endcase
      end
   end

   assign busy = (st == P_WAIT);
   assign land = busy && rvalid;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !rvalid |=> busy && $stable(ptr_addr)); // R8
   AST_LAUNCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && launch |=> busy && ptr_addr == $past(ptr_in)); // R8
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
   parameter int AW       = 32,
   parameter int DISP_W   = 16,
   parameter bit SCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [1:0]        size_code,
   input  logic [AW-1:0]     base,
   input  logic [AW-1:0]     index,
   input  logic [DISP_W-1:0] disp,
   output logic [AW-1:0]     addr,
   output logic              wb_en,
   output logic [AW-1:0]     wb_data,
   output logic              done,
   output logic              busy,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_rvalid,
   input  logic [AW-1:0]     mem_rdata
);
   import eag_pkg::*;

   generate
      if (AW < DISP_W) begin : g_bad_width
         $error("eff_addr_gen: AW must be at least DISP_W");
      end
      if (AW < 8) begin : g_bad_aw
         $error("eff_addr_gen: AW must be at least 8");
      end
   endgenerate

   amode_e        mode_e, mode_q;
   logic [AW-1:0] disp_x, step, sidx, c_ea, c_wb;
   logic          c_wb_en, c_ind, accept, land;
   logic [AW-1:0] addr_q, wb_q;
   logic          done_q, wb_en_q;

   assign mode_e = amode_e'(mode);
   assign accept = start && !busy;

   eag_sext #(.DISP_W(DISP_W), .AW(AW)) u_sext (.raw(disp), .ext(disp_x));

   eag_step #(.AW(AW), .SCALE_EN(SCALE_EN)) u_step (
      .size_code(size_code), .index(index), .step(step), .scaled_index(sidx));

   eag_calc #(.AW(AW)) u_calc (
      .mode(mode_e), .base(base), .index(index), .scaled_index(sidx),
      .disp_x(disp_x), .step(step), .ea(c_ea), .wb_en(c_wb_en),
      .wb_val(c_wb), .indirect(c_ind));

   eag_ptr_ctl #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .launch(accept && c_ind), .ptr_in(base),
      .rvalid(mem_rvalid), .busy(busy), .ptr_addr(mem_addr), .land(land));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         wb_en_q <= 1'b0;
         addr_q  <= '0;
         wb_q    <= '0;
         mode_q  <= AM_DISP;
      end else begin
         done_q  <= 1'b0;
         wb_en_q <= 1'b0;
         if (land) begin
            done_q <= 1'b1;
            addr_q <= mem_rdata;
            mode_q <= AM_MEMIND;
         end else if (accept && !c_ind) begin
            done_q  <= 1'b1;
            addr_q  <= c_ea;
            wb_en_q <= c_wb_en;
            wb_q    <= c_wb;
            mode_q  <= mode_e;
         end
      end
   end

   assign addr    = addr_q;
   assign wb_en   = wb_en_q;
   assign wb_data = wb_q;
   assign done    = done_q;
   assign mem_req = busy;

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !c_ind |=> done && !busy); // R1
   AST_WB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done && (mode_q == AM_POSTINC || mode_q == AM_PREDEC)); // R7
   AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      done && mode_q == AM_PREDEC |-> wb_en && wb_data == addr); // R6
   AST_POSTINC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      done && mode_q == AM_POSTINC |-> wb_data == addr + ($past(step))); // R5
   AST_IND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      land |=> done && !wb_en && addr == $past(mem_rdata)); // R8
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_rvalid |=> !done); // R9
endmodule

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    mode = '0;
   logic [1:0]    size_code = '0;
   logic [AW-1:0] base = '0, index = '0;
   logic [15:0]   disp = '0;
   logic [AW-1:0] addr, wb_data, mem_addr;
   logic          wb_en, done, busy, mem_req;
   logic          mem_rvalid = 1'b0;
   logic [AW-1:0] mem_rdata = '0;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   eff_addr_gen #(.AW(AW)) i_eff_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .size_code(size_code), .base(base), .index(index), .disp(disp),
      .addr(addr), .wb_en(wb_en), .wb_data(wb_data), .done(done),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

   task automatic chk(input bit ok, input string req,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input int m);
      case (m)
         0: return "R1 disp";
         1: return "R2 regind";
         2: return "R3 indexed";
         3: return "R2 absolute";
         5: return "R5 postinc";
         6: return "R6 predec";
         default: return "R4 scaled";
      endcase
   endfunction

   task automatic expect_of(input int m, input int sz, input logic [AW-1:0] b,
                            input logic [AW-1:0] ix, input logic [15:0] d,
                            output logic [AW-1:0] ea, output logic we,
                            output logic [AW-1:0] wv);
      int s;
      logic [AW-1:0] st, dx;
      s  = (sz == 3) ? 2 : sz;
      st = AW'(1) << s;
      dx = {{16{d[15]}}, d};
      we = 1'b0;
      wv = 'x;
      case (m)
         0: ea = b + dx;
         1: ea = b;
         2: ea = b + ix;
         3: ea = dx;
         5: begin ea = b; we = 1'b1; wv = b + st; end
         6: begin ea = b - st; we = 1'b1; wv = b - st; end
         default: ea = dx + b + (ix << s);
      endcase
   endtask

   task automatic direct_op(input int m, input int sz, input logic [AW-1:0] b,
                            input logic [AW-1:0] ix, input logic [15:0] d);
      logic [AW-1:0] ea, wv;
      logic we;
      string t;
      expect_of(m, sz, b, ix, d, ea, we, wv);
      t = tag_of(m);
      @(negedge clk);
      start = 1'b1; mode = 3'(m); size_code = 2'(sz);
      base = b; index = ix; disp = d;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, {t, " R1 done"}, AW'(done), AW'(1));
      chk(addr === ea, {t, " addr"}, addr, ea);
      chk(wb_en === we, {t, " R7 wb_en"}, AW'(wb_en), AW'(we));
      if (we) chk(wb_data === wv, {t, " wb_data"}, wb_data, wv);
      @(negedge clk);
      chk(done === 1'b0, "R1 single-cycle done", AW'(done), AW'(0));
   endtask

   task automatic ind_op(input logic [AW-1:0] b, input logic [AW-1:0] ptr,
                         input int waits);
      @(negedge clk);
      start = 1'b1; mode = 3'd4; size_code = 2'd2; base = b;
      index = 32'h55; disp = 16'h0010;
      @(negedge clk);
      start = 1'b0;
      chk(mem_req === 1'b1 && busy === 1'b1, "R8 req raised", AW'(mem_req), AW'(1));
      chk(mem_addr === b, "R8 mem_addr", mem_addr, b);
      chk(done === 1'b0, "R8 no early done", AW'(done), AW'(0));
      for (int w = 0; w < waits; w++) begin
         start = (w == 0); mode = 3'd0; base = ~b;
         @(negedge clk);
         start = 1'b0;
         chk(done === 1'b0, "R9 start ignored while busy", AW'(done), AW'(0));
         chk(mem_req === 1'b1 && mem_addr === b, "R8/R9 req held", mem_addr, b);
      end
      mem_rvalid = 1'b1; mem_rdata = ptr;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = '0;
      chk(done === 1'b1, "R8 done after rvalid", AW'(done), AW'(1));
      chk(addr === ptr, "R8 addr from pointer", addr, ptr);
      chk(wb_en === 1'b0, "R7 no wb in memind", AW'(wb_en), AW'(0));
      chk(busy === 1'b0 && mem_req === 1'b0, "R8 req dropped", AW'(mem_req), AW'(0));
   endtask

   logic [AW-1:0] vb [6] = '{32'h0000_0000, 32'h0000_1000, 32'h7FFF_FFFE,
                            32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
   logic [AW-1:0] vi [6] = '{32'h0000_0003, 32'hFFFF_FFFF, 32'h4000_0001,
                            32'h0000_0000, 32'h0000_0010, 32'hC000_0002};
   logic [15:0]   vd [6] = '{16'h0000, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h0004, 16'hFFF0};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done === 1'b0, "R1 reset done", AW'(done), AW'(0));
      chk(busy === 1'b0 && mem_req === 1'b0, "R8 reset idle", AW'(mem_req), AW'(0));
      chk(wb_en === 1'b0, "R7 reset wb_en", AW'(wb_en), AW'(0));
      for (int m = 0; m < 8; m++) begin
         if (m == 4) continue;
         for (int sz = 0; sz < 4; sz++)
            for (int v = 0; v < 6; v++)
               direct_op(m, sz, vb[v], vi[v], vd[v]);
      end
      ind_op(32'h0000_0100, 32'hDEAD_BEE0, 0);
      ind_op(32'hFFFF_FFFC, 32'h0000_0004, 3);
      ind_op(32'h8000_0000, 32'h7FFF_FFFF, 7);
      direct_op(6, 0, 32'h0, 32'h0, 16'h0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule